// File: doc/BRIEF.md
# Pseudo-SRAM Power-Down Sequencer

This block sits on the host side of a pseudo-SRAM and is the only driver of the memory's high-active second chip enable. It brings the memory out of its supply ramp, and later puts it into its low-power idle state and takes it out again. While the second chip enable is low, the memory is in power-down. Every transition on that enable must respect three things: a setup window on the first chip enable, a minimum low time, and an exit hold.

The sequencer drives two more outputs. A hold-off output forces the first chip enable high, and a ready flag gates the read/write controller. A power-down request is a level. It is honoured only once the controller reports idle, and it is released only when the request drops. The length of the exit hold depends on one thing: whether a partial-retention mode was in force when the memory entered power-down. All timing windows are parameters counted in clock cycles.

Top module: `pdseq_top`

## Requirements
- R1: During and straight after reset, `ce2` is low, `ce1_hold` is high and `ready` is low.
- R2: `ce2` stays low until `pwr_good` is seen high. It rises exactly `PUP_CYC` cycles after the first clock edge that samples `pwr_good` high.
- R3: `ce1_hold` rises the cycle after the sequencer sees the controller idle. `ce2` then falls exactly `SETUP_CYC` cycles later, so the first chip enable is held high with `ce2` still high for at least `SETUP_CYC` cycles before entry.
- R4: Once low, `ce2` stays low for at least `LOWMIN_CYC` cycles and for as long as `pd_req` stays high. It rises on the first edge where both conditions are met.
- R5: `ce1_hold` is already high when `ce2` rises. It stays high for the exit hold, and `ready` rises in the same cycle that `ce1_hold` falls.
- R6: The exit hold is `LONG_CYC` cycles after power-up, or after a power-down entered with `partial_mode` = 0 (full sleep). It is `SHORT_CYC` cycles after a power-down entered with `partial_mode` = 1.
- R7: A request that arrives while `ctrl_idle` is low drops `ready`, but leaves `ce2` high and `ce1_hold` low until `ctrl_idle` goes high.
- R8: If `pd_req` falls before the controller goes idle, `ready` returns high on the edge after the fall, and no power-down takes place.
- R9: `partial_mode` is sampled on the edge where `ce2` falls. Changing it during power-down has no effect on the exit hold.
- R10: `ready` is high only while `ce2` is high and `ce1_hold` is low. It falls on the edge after `pd_req` is first sampled high in the ready state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply has reached its operating level |
| pd_req | input | 1 | Level request to hold the memory in power-down |
| partial_mode | input | 1 | 1 when a partial-retention mode has been programmed |
| ctrl_idle | input | 1 | Read/write controller has no access in flight |
| ce2 | output | 1 | High-active second chip enable to the memory |
| ce1_hold | output | 1 | Forces the first chip enable high (deselected) |
| ready | output | 1 | Read/write controller may issue accesses |

## Verification
The scoreboard predicts the exact cycle of every edge on the three outputs. A design whose setup, minimum-low or exit-hold counter is off by one therefore shows up as a mismatch in cycle rather than a missing event. The bench holds the request for only one cycle past entry, so a design that released on the request alone would raise `ce2` before the minimum low time. It changes `partial_mode` during power-down in both directions, which exposes a design that reads the flag live instead of latching it at entry. It also keeps the controller busy, both until it goes idle and until the request is withdrawn. A sequencer that ignored `ctrl_idle`, or that could not back out of a pending request, would raise `ce1_hold` or lower `ce2` without any prediction for that edge.

// File: rtl/pdseq_pkg.sv
// Shared types for the power-down sequencer.
package pdseq_pkg;

    // Sequencer phases; each maps to one fixed output pattern.
    typedef enum logic [2:0] {
        ST_PUP    = 3'd0,  // waiting for supply good, ce2 low
        ST_PUPLOW = 3'd1,  // supply good, ce2 held low for the power-up window
        ST_HOLD   = 3'd2,  // ce2 high, first chip enable still held off
        ST_RUN    = 3'd3,  // normal operation, ready high
        ST_DRAIN  = 3'd4,  // request pending, waiting for controller idle
        ST_SETUP  = 3'd5,  // first chip enable held off before ce2 falls
        ST_DOWN   = 3'd6   // ce2 low, memory in power-down
    } pdseq_state_e;

endpackage

// File: rtl/pdseq_timer.sv
// Down-counter used for every timed window of the sequencer.
// Assumes: the load value is the window length minus one; done is high
// while the count is zero, so a window of N cycles ends N edges after load.
module pdseq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new window or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/pdseq_mode_latch.sv
// Captures the retention-mode flag at the moment of power-down entry.
// Assumes: capture is a one-cycle strobe on the edge where ce2 falls.
module pdseq_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic partial_mode,
    output logic partial_q
);

    // Hold the flag that governs the next exit hold; reset means full sleep.
    always_ff @(posedge clk) begin
        if (!rst_n)
            partial_q <= 1'b0;
        else if (capture)
            partial_q <= partial_mode;
    end

endmodule

// File: rtl/pdseq_fsm.sv
// Phase controller: walks power-up, drain, setup, power-down and exit hold,
// loads the shared timer and drives registered outputs.
// Assumes: every *_CYC parameter is at least 1.
module pdseq_fsm
    import pdseq_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int SETUP_CYC  = 1,
    parameter int LOWMIN_CYC = 7,
    parameter int PUP_CYC    = 5000,
    parameter int LONG_CYC   = 30000,
    parameter int SHORT_CYC  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic             pd_req,
    input  logic             ctrl_idle,
    input  logic             tmr_done,
    input  logic             partial_q,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             mode_capture,
    output logic             ce2,
    output logic             ce1_hold,
    output logic             ready
);

    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LOWMIN_LD = CNT_W'(LOWMIN_CYC - 1);
    localparam logic [CNT_W-1:0] PUP_LD    = CNT_W'(PUP_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_LD   = CNT_W'(LONG_CYC - 1);
    localparam logic [CNT_W-1:0] SHORT_LD  = CNT_W'(SHORT_CYC - 1);

    pdseq_state_e st_q, st_nxt;

    // Next phase and the timer load that opens each timed window.
    always_comb begin
        st_nxt       = st_q;
        tmr_load     = 1'b0;
        tmr_val      = '0;
        mode_capture = 1'b0;
        case (st_q)
            ST_PUP: if (pwr_good) begin
                st_nxt   = ST_PUPLOW;
                tmr_load = 1'b1;
                tmr_val  = PUP_LD;
            end
            ST_PUPLOW: if (tmr_done) begin
                st_nxt   = ST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = LONG_LD;
            end
            ST_HOLD: if (tmr_done) st_nxt = ST_RUN;
            ST_RUN:  if (pd_req)   st_nxt = ST_DRAIN;
            ST_DRAIN: begin
                if (!pd_req) begin
                    st_nxt = ST_RUN;
                end else if (ctrl_idle) begin
                    st_nxt   = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = SETUP_LD;
                end
            end
            ST_SETUP: if (tmr_done) begin
                st_nxt       = ST_DOWN;
                tmr_load     = 1'b1;
                tmr_val      = LOWMIN_LD;
                mode_capture = 1'b1;
            end
            ST_DOWN: if (tmr_done && !pd_req) begin
                st_nxt   = ST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = partial_q ? SHORT_LD : LONG_LD;
            end
            default: st_nxt = ST_PUP;
        endcase
    end

    // Phase register plus registered outputs decoded from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_PUP;
            ce2      <= 1'b0;
            ce1_hold <= 1'b1;
            ready    <= 1'b0;
        end else begin
            st_q     <= st_nxt;
            ce2      <= !(st_nxt == ST_PUP || st_nxt == ST_PUPLOW || st_nxt == ST_DOWN);
            ce1_hold <= !(st_nxt == ST_RUN || st_nxt == ST_DRAIN);
            ready    <= (st_nxt == ST_RUN);
        end
    end

endmodule

// File: rtl/pdseq_top.sv
// Power-down sequencer top: owns the memory's second chip enable, the
// hold-off of its first chip enable and the ready gate of the controller.
// Assumes: all windows are given in clock cycles and are at least 1.
module pdseq_top #(
    parameter int SETUP_CYC  = 1,
    parameter int LOWMIN_CYC = 7,
    parameter int PUP_CYC    = 5000,
    parameter int LONG_CYC   = 30000,
    parameter int SHORT_CYC  = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic pd_req,
    input  logic partial_mode,
    input  logic ctrl_idle,
    output logic ce2,
    output logic ce1_hold,
    output logic ready
);

    localparam int MAX_A   = (SETUP_CYC > LOWMIN_CYC) ? SETUP_CYC : LOWMIN_CYC;
    localparam int MAX_B   = (PUP_CYC > LONG_CYC) ? PUP_CYC : LONG_CYC;
    localparam int MAX_C   = (MAX_A > SHORT_CYC) ? MAX_A : SHORT_CYC;
    localparam int MAX_CYC = (MAX_B > MAX_C) ? MAX_B : MAX_C;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             mode_capture;
    logic             partial_q;

    pdseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    pdseq_mode_latch u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (mode_capture),
        .partial_mode (partial_mode),
        .partial_q    (partial_q)
    );

    pdseq_fsm #(
        .CNT_W      (CNT_W),
        .SETUP_CYC  (SETUP_CYC),
        .LOWMIN_CYC (LOWMIN_CYC),
        .PUP_CYC    (PUP_CYC),
        .LONG_CYC   (LONG_CYC),
        .SHORT_CYC  (SHORT_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_good     (pwr_good),
        .pd_req       (pd_req),
        .ctrl_idle    (ctrl_idle),
        .tmr_done     (tmr_done),
        .partial_q    (partial_q),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .mode_capture (mode_capture),
        .ce2          (ce2),
        .ce1_hold     (ce1_hold),
        .ready        (ready)
    );

endmodule

// File: rtl/pdseq_chk.sv
// Protocol checker for pdseq_top, attached by bind. Measures the timing
// windows at the ports with counters instead of deep $past chains.
module pdseq_chk #(
    parameter int SETUP_CYC  = 1,
    parameter int LOWMIN_CYC = 7,
    parameter int SHORT_CYC  = 7
) (
    input logic clk,
    input logic rst_n,
    input logic pd_req,
    input logic ctrl_idle,
    input logic ce2,
    input logic ce1_hold,
    input logic ready
);

    logic [31:0] both_hi_cnt;
    logic [31:0] low_cnt;
    logic        up_seen;

    // Count consecutive cycles with ce2 high and the first enable held off.
    always_ff @(posedge clk) begin
        if (!rst_n)                both_hi_cnt <= '0;
        else if (ce2 && ce1_hold)  both_hi_cnt <= both_hi_cnt + 32'd1;
        else                       both_hi_cnt <= '0;
    end

    // Count consecutive cycles with ce2 low.
    always_ff @(posedge clk) begin
        if (!rst_n)   low_cnt <= '0;
        else if (!ce2) low_cnt <= low_cnt + 32'd1;
        else          low_cnt <= '0;
    end

    // Note that the power-up window has passed.
    always_ff @(posedge clk) begin
        if (!rst_n)   up_seen <= 1'b0;
        else if (ce2) up_seen <= 1'b1;
    end

    a_r3_entry_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce2) |-> both_hi_cnt >= 32'(SETUP_CYC));

    a_r4_low_min: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ce2) && up_seen) |-> low_cnt >= 32'(LOWMIN_CYC));

    a_r5_hold_at_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce2) |-> ce1_hold);

    a_r6_hold_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce1_hold) |-> both_hi_cnt >= 32'(SHORT_CYC));

    a_r7_idle_before_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce1_hold) |-> $past(ctrl_idle));

    a_r10_ready_state: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ce2 && !ce1_hold));

    a_r10_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && pd_req) |=> !ready);

endmodule

bind pdseq_top pdseq_chk #(
    .SETUP_CYC  (SETUP_CYC),
    .LOWMIN_CYC (LOWMIN_CYC),
    .SHORT_CYC  (SHORT_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_req    (pd_req),
    .ctrl_idle (ctrl_idle),
    .ce2       (ce2),
    .ce1_hold  (ce1_hold),
    .ready     (ready)
);

// File: tb/sim_pdseq_top.sv
// Scoreboard bench: driver tasks predict every output edge with its cycle,
// a monitor pops and compares them as the edges appear.
module sim_pdseq_top;

    localparam int CLK_PERIOD = 10;
    localparam int TS  = 2;
    localparam int TL  = 4;
    localparam int TP  = 20;
    localparam int TLG = 30;
    localparam int TSH = 3;

    typedef struct {
        int    sig;   // 0 = ce2, 1 = ce1_hold, 2 = ready
        bit    val;
        int    cyc;
        string tag;
    } ev_t;

    logic clk = 1'b0;
    logic rst_n, pwr_good, pd_req, partial_mode, ctrl_idle;
    logic ce2, ce1_hold, ready;

    int  cyc = 0;
    int  total = 0;
    int  bad = 0;
    bit  mon_on = 1'b0;
    ev_t exp_q[$];

    pdseq_top #(
        .SETUP_CYC(TS), .LOWMIN_CYC(TL), .PUP_CYC(TP),
        .LONG_CYC(TLG), .SHORT_CYC(TSH)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pd_req(pd_req),
        .partial_mode(partial_mode), .ctrl_idle(ctrl_idle),
        .ce2(ce2), .ce1_hold(ce1_hold), .ready(ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(int sig, bit val, int at, string tag);
        ev_t e;
        e.sig = sig; e.val = val; e.cyc = at; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic chk(string tag, bit ok, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic take(int sig, bit val);
        ev_t e;
        total++;
        if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL unexpected edge: actual sig=%0d val=%0d cyc=%0d expected none", sig, val, cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.sig != sig || e.val != val || e.cyc != cyc) begin
                bad++;
                $display("FAIL %s: actual sig=%0d val=%0d cyc=%0d expected sig=%0d val=%0d cyc=%0d",
                         e.tag, sig, val, cyc, e.sig, e.val, e.cyc);
            end
        end
    endtask

    // Monitor: turn each output change into an event and score it.
    initial begin : monitor
        logic p_ce2, p_hold, p_rdy;
        wait (mon_on);
        p_ce2 = ce2; p_hold = ce1_hold; p_rdy = ready;
        forever begin
            @(negedge clk);
            if (ce2 != p_ce2)       take(0, ce2);
            if (ce1_hold != p_hold) take(1, ce1_hold);
            if (ready != p_rdy)     take(2, ready);
            p_ce2 = ce2; p_hold = ce1_hold; p_rdy = ready;
        end
    end

    // One full power-down with an idle controller; K = cycles the request
    // stays high after ce2 falls; flip inverts partial_mode during power-down.
    task automatic pd_cycle(bit part, int k, bit flip, string tag);
        int c, e, d, rise, h;
        c = cyc;
        partial_mode = part; ctrl_idle = 1'b1; pd_req = 1'b1;
        push(2, 1'b0, c + 1, "R10");
        push(1, 1'b1, c + 2, "R3");
        e = c + 2 + TS;
        push(0, 1'b0, e, "R3");
        wait_until(e);
        if (flip) partial_mode = !part;
        d = e + k;
        wait_until(d);
        chk("R4", ce2 == 1'b0, ce2, 0);
        pd_req = 1'b0;
        rise = (d + 1 > e + TL) ? d + 1 : e + TL;
        h = part ? TSH : TLG;
        push(0, 1'b1, rise, "R4");
        push(1, 1'b0, rise + h, tag);
        push(2, 1'b1, rise + h, tag);
        wait_until(rise + h + 2);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : driver
        int c, c2, e;
        rst_n = 1'b0; pwr_good = 1'b0; pd_req = 1'b0;
        partial_mode = 1'b0; ctrl_idle = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", ce2 == 1'b0, ce2, 0);
        chk("R1", ce1_hold == 1'b1, ce1_hold, 1);
        chk("R1", ready == 1'b0, ready, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", ce2 == 1'b0 && ce1_hold == 1'b1 && ready == 1'b0,
            {ce2, ce1_hold, ready}, 3'b010);
        mon_on = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2", ce2 == 1'b0, ce2, 0);

        // Power-up: long hold after the low window.
        c = cyc;
        pwr_good = 1'b1;
        push(0, 1'b1, c + 1 + TP, "R2");
        push(1, 1'b0, c + 1 + TP + TLG, "R6");
        push(2, 1'b1, c + 1 + TP + TLG, "R5");
        wait_until(c + 1 + TP + TLG + 2);
        chk("R5", ready == 1'b1, ready, 1);

        pd_cycle(1'b0, 10, 1'b0, "R6");   // full sleep, long hold
        pd_cycle(1'b1, 10, 1'b0, "R6");   // partial, short hold
        pd_cycle(1'b0, 0, 1'b0, "R4");    // release at once, minimum low time
        pd_cycle(1'b1, 0, 1'b1, "R9");    // flag cleared during power-down
        pd_cycle(1'b0, 2, 1'b1, "R9");    // flag set during power-down

        // R7: request while the controller is busy.
        c = cyc;
        ctrl_idle = 1'b0; pd_req = 1'b1;
        push(2, 1'b0, c + 1, "R7");
        wait_until(c + 6);
        chk("R7", ce2 == 1'b1, ce2, 1);
        chk("R7", ce1_hold == 1'b0, ce1_hold, 0);
        c2 = cyc;
        ctrl_idle = 1'b1; partial_mode = 1'b0;
        push(1, 1'b1, c2 + 1, "R7");
        e = c2 + 1 + TS;
        push(0, 1'b0, e, "R7");
        wait_until(e);
        pd_req = 1'b0;
        push(0, 1'b1, e + TL, "R4");
        push(1, 1'b0, e + TL + TLG, "R6");
        push(2, 1'b1, e + TL + TLG, "R5");
        wait_until(e + TL + TLG + 2);

        // R8: request withdrawn before the controller goes idle.
        c = cyc;
        ctrl_idle = 1'b0; pd_req = 1'b1;
        push(2, 1'b0, c + 1, "R8");
        wait_until(c + 3);
        pd_req = 1'b0;
        push(2, 1'b1, c + 4, "R8");
        wait_until(c + 8);
        chk("R8", ce2 == 1'b1, ce2, 1);
        chk("R8", ce1_hold == 1'b0, ce1_hold, 0);
        chk("R10", ready == 1'b1, ready, 1);
        ctrl_idle = 1'b1;
        repeat (3) @(negedge clk);

        chk("R5", exp_q.size() == 0, exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule